// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

A memory-mapped watchdog built around a 32-bit down-counter. Software programs a reload value, arms the counter by writing a fixed 16-bit key to a restart register, and sets the watchdog's behaviour through a control word. That word holds an enable, a reset request, an interrupt enable, an external-signal enable, a tick-source select, a two-bit reset-scope code and an alternate-boot request. The counter decrements either on every clock or only on a 1 MHz tick enable supplied from outside. With that tick, the longest timeout is roughly 4295 seconds.

When the count reaches zero while counting is enabled, the block stops counting and records a timeout. It can also pulse a reset request, pulse an external signal and latch an alternate-boot request. An early-warning threshold lives in the upper bits of the control word. Once the count falls to that threshold, a sticky interrupt is raised, so software gets a chance to service the watchdog before the reset fires. Software clears the recorded events through a dedicated clear register.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the count and the reload value both read 0x01C9C380, the control and status words read 0, and irq, reset_req, ext_signal, alt_boot_req and reset_scope are all 0.
- R2: A write to offset 0x08 whose low 16 bits equal 0x4755 copies the reload value into the count on that clock edge and resumes a stopped counter. A write there with any other low 16 bits leaves the count unchanged.
- R3: While enabled and not stopped, the count drops by exactly one on every clock when control bit 4 is 0. When bit 4 is 1, it drops only on clocks where tick_1m is high.
- R4: When the count is 0 with control bit 0 set, the next edge sets status bit 0 and stops counting until the next restart. On that same edge, reset_req goes high for exactly one clock if control bit 1 is set, and ext_signal does the same if control bit 3 is set. With bit 1 clear, reset_req stays low.
- R5: With control bit 0 clear, the count holds its value. A write to the reload register (offset 0x04) does not change the count.
- R6: reset_scope always equals control bits 6:5 (0 SoC, 1 full chip, 2 CPU only).
- R7: While running with control bit 2 set, the interrupt becomes pending once the count is at or below {control[31:10], 10'b0}. Pending drives irq high and sets status bit 2 until cleared. With bit 2 clear, no interrupt is raised.
- R8: A write to offset 0x14 with bit 0 set clears status bits 2:0 and irq. The same write with bit 0 clear has no effect.
- R9: An expiry with control bit 7 set raises alt_boot_req and status bit 1, both held until cleared.
- R10: Reads are combinational on bus_addr: 0x00 count, 0x04 reload, 0x08 zero, 0x0C control, 0x10 status (bit 0 timeout, bit 1 alternate boot, bit 2 interrupt pending), 0x14 zero. Reload and control read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1m | input | 1 | 1 MHz tick enable, used when control bit 4 is set |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Early-warning interrupt pending |
| reset_req | output | 1 | One-clock reset request on expiry |
| reset_scope | output | 2 | Selected reset scope |
| ext_signal | output | 1 | One-clock external signal on expiry |
| alt_boot_req | output | 1 | Latched alternate-boot request |

## Verification
The countdown is exercised in several ways. Running on every clock lets the number of cycles from enable to the reset pulse be compared exactly against reload plus one. Running on held and single-pulsed ticks separates the two tick sources. Disabling mid-run shows freezing, as distinct from counting. Restart writes are tried with a near-miss key and with the true key, which separates key matching from any write to that offset. The early-warning test counts the exact cycle at which the interrupt rises, then repeats the run with interrupts disabled. The expiry paths are run with and without the reset and alternate-boot bits, so each output is seen both firing and staying quiet.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DW     = 32;
    localparam int ADDR_W = 5;
    localparam int ST_W   = 3;

    localparam logic [ADDR_W-1:0] OFF_COUNT   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_RELOAD  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_RESTART = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_CLEAR   = 5'h14;

    localparam int CB_EN     = 0;
    localparam int CB_RST    = 1;
    localparam int CB_IRQ    = 2;
    localparam int CB_EXT    = 3;
    localparam int CB_TICK   = 4;
    localparam int CB_SCOPE  = 5;
    localparam int CB_ALT    = 7;
    localparam int CB_THR_LO = 10;

    localparam int ST_TMO = 0;
    localparam int ST_ALT = 1;
    localparam int ST_IRQ = 2;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] reload;
    } regs_t;

    typedef struct packed {
        logic [DW-1:0] count;
        logic          halted;
        logic          tmo;
        logic          alt;
        logic          irq;
        logic          rst_p;
        logic          ext_p;
    } core_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter logic [DW-1:0] DEFAULT_RELOAD = 32'h01C9_C380,
    parameter logic [15:0]   RESTART_KEY    = 16'h4755
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     count_i,
    input  logic [ST_W-1:0]   status_i,
    output logic [DW-1:0]     ctrl_o,
    output logic [DW-1:0]     reload_o,
    output logic              restart_o,
    output logic              clear_o,
    output logic [DW-1:0]     rdata_o
);
    regs_t regs_d, regs_q;
    logic  wr;

    always_comb begin
        wr        = bus_sel && bus_we;
        regs_d    = regs_q;
        if (wr && bus_addr == OFF_RELOAD) regs_d.reload = bus_wdata;
        if (wr && bus_addr == OFF_CTRL)   regs_d.ctrl   = bus_wdata;
        restart_o = wr && (bus_addr == OFF_RESTART) && (bus_wdata[15:0] == RESTART_KEY);
        clear_o   = wr && (bus_addr == OFF_CLEAR) && bus_wdata[0];
        case (bus_addr)
            OFF_COUNT:  rdata_o = count_i;
            OFF_RELOAD: rdata_o = regs_q.reload;
            OFF_CTRL:   rdata_o = regs_q.ctrl;
            OFF_STATUS: rdata_o = {{(DW-ST_W){1'b0}}, status_i};
            default:    rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl   <= '0;
            regs_q.reload <= DEFAULT_RELOAD;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl_o   = regs_q.ctrl;
    assign reload_o = regs_q.reload;

    // R10: reload register holds what the bus last wrote to it
    a_r10_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == OFF_RELOAD) |=> (regs_q.reload == $past(bus_wdata)));
    // R10: control word is untouched by writes to other offsets
    a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we && bus_addr == OFF_CTRL) |=> $stable(regs_q.ctrl));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter logic [DW-1:0] DEFAULT_RELOAD = 32'h01C9_C380
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   ctrl_i,
    input  logic [DW-1:0]   reload_i,
    input  logic            restart_i,
    input  logic            clear_i,
    input  logic            tick_i,
    output logic [DW-1:0]   count_o,
    output logic [ST_W-1:0] status_o,
    output logic            reset_req_o,
    output logic            ext_sig_o,
    output logic            alt_boot_o,
    output logic            irq_o
);
    core_t         cur_d, cur_q;
    logic          step;
    logic          running;
    logic          expire;
    logic          pre_hit;
    logic [DW-1:0] thr;

    always_comb begin
        thr     = {ctrl_i[DW-1:CB_THR_LO], {CB_THR_LO{1'b0}}};
        step    = ctrl_i[CB_TICK] ? tick_i : 1'b1;
        running = ctrl_i[CB_EN] && !cur_q.halted;
        expire  = running && (cur_q.count == '0);
        pre_hit = running && ctrl_i[CB_IRQ] && (cur_q.count <= thr);

        cur_d       = cur_q;
        cur_d.rst_p = 1'b0;
        cur_d.ext_p = 1'b0;
        if (clear_i) begin
            cur_d.tmo = 1'b0;
            cur_d.alt = 1'b0;
            cur_d.irq = 1'b0;
        end
        if (restart_i) begin
            cur_d.count  = reload_i;
            cur_d.halted = 1'b0;
        end else if (expire) begin
            cur_d.halted = 1'b1;
            cur_d.tmo    = 1'b1;
            cur_d.rst_p  = ctrl_i[CB_RST];
            cur_d.ext_p  = ctrl_i[CB_EXT];
            if (ctrl_i[CB_ALT]) cur_d.alt = 1'b1;
        end else if (running && step) begin
            cur_d.count = cur_q.count - DW'(1);
        end
        if (pre_hit) cur_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.count <= DEFAULT_RELOAD;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign count_o     = cur_q.count;
    assign status_o    = {cur_q.irq, cur_q.alt, cur_q.tmo};
    assign reset_req_o = cur_q.rst_p;
    assign ext_sig_o   = cur_q.ext_p;
    assign alt_boot_o  = cur_q.alt;
    assign irq_o       = cur_q.irq;

    // R2: a restart strobe loads the reload value
    a_r2_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cur_q.count == $past(reload_i)));
    // R3: without restart the count moves by at most one per clock
    a_r3_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> (cur_q.count == $past(cur_q.count) || cur_q.count == $past(cur_q.count) - DW'(1)));
    // R4: reset request is a single-clock pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.rst_p |=> !cur_q.rst_p);
    // R4: a stopped counter stays put until restarted
    a_r4_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.halted && !restart_i) |=> $stable(cur_q.count));
    // R5: disabled counter is frozen
    a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i[CB_EN] && !restart_i) |=> $stable(cur_q.count));
    // R8: clear with no counting leaves every status bit low
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !ctrl_i[CB_EN]) |=> (status_o == '0));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdt_pkg::*;
#(
    parameter logic [DW-1:0] DEFAULT_RELOAD = 32'h01C9_C380,
    parameter logic [15:0]   RESTART_KEY    = 16'h4755
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1m,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              reset_req,
    output logic [1:0]        reset_scope,
    output logic              ext_signal,
    output logic              alt_boot_req
);
    logic [DW-1:0]   ctrl;
    logic [DW-1:0]   reload;
    logic [DW-1:0]   count;
    logic [ST_W-1:0] status;
    logic            restart;
    logic            clear;

    wdt_regfile #(
        .DEFAULT_RELOAD(DEFAULT_RELOAD),
        .RESTART_KEY   (RESTART_KEY)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .count_i  (count),
        .status_i (status),
        .ctrl_o   (ctrl),
        .reload_o (reload),
        .restart_o(restart),
        .clear_o  (clear),
        .rdata_o  (bus_rdata)
    );

    wdt_counter #(
        .DEFAULT_RELOAD(DEFAULT_RELOAD)
    ) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .reload_i   (reload),
        .restart_i  (restart),
        .clear_i    (clear),
        .tick_i     (tick_1m),
        .count_o    (count),
        .status_o   (status),
        .reset_req_o(reset_req),
        .ext_sig_o  (ext_signal),
        .alt_boot_o (alt_boot_req),
        .irq_o      (irq)
    );

    assign reset_scope = ctrl[CB_SCOPE+1:CB_SCOPE];

    // R6: scope output tracks the control field it comes from
    a_r6_scope_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ctrl) |-> $stable(reset_scope));
endmodule

// File: tb/tick_watchdog_tb.sv
`timescale 1ns/100ps
module tick_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1m = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, reset_req, ext_signal, alt_boot_req;
    logic [1:0]  reset_scope;

    int total = 0;
    int fails = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    tick_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .reset_req(reset_req), .reset_scope(reset_scope),
        .ext_signal(ext_signal), .alt_boot_req(alt_boot_req)
    );

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", total - fails, total);
        end
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); check("R1", "count", v, 32'h01C9C380);
        rd(5'h04, v); check("R1", "reload", v, 32'h01C9C380);
        rd(5'h0C, v); check("R1", "ctrl", v, 0);
        rd(5'h10, v); check("R1", "status", v, 0);
        check("R1", "outputs", {27'd0, irq, reset_req, ext_signal, alt_boot_req, reset_scope == 2'd0}, 32'd1);
    endtask

    task automatic t_restart_key();
        logic [31:0] v;
        wr(5'h04, 32'd100);
        rd(5'h04, v); check("R10", "reload readback", v, 100);
        rd(5'h00, v); check("R5", "reload write leaves count", v, 32'h01C9C380);
        wr(5'h08, 32'h0000_4756);
        rd(5'h00, v); check("R2", "wrong key ignored", v, 32'h01C9C380);
        rd(5'h08, v); check("R10", "restart reads zero", v, 0);
        wr(5'h08, 32'h0000_4755);
        rd(5'h00, v); check("R2", "key loads count", v, 100);
        wr(5'h0C, 32'h1234_5660);
        rd(5'h0C, v); check("R10", "ctrl readback", v, 32'h1234_5660);
        check("R6", "scope field", {30'd0, reset_scope}, 32'd3);
        rd(5'h00, v); check("R5", "disabled ctrl write holds count", v, 100);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        wr(5'h0C, 32'h1);
        wr(5'h0C, 32'h0);
        rd(5'h00, v); check("R3", "two clocks of counting", v, 98);
        idle(10);
        rd(5'h00, v); check("R5", "frozen while disabled", v, 98);
        wr(5'h04, 32'd7);
        rd(5'h00, v); check("R5", "reload write while frozen", v, 98);
    endtask

    task automatic t_tick();
        logic [31:0] v;
        wr(5'h04, 32'd3);
        wr(5'h08, 32'h4755);
        tick_1m = 1'b0;
        wr(5'h0C, 32'h11);
        idle(10);
        rd(5'h00, v); check("R3", "no tick no decrement", v, 3);
        tick_1m = 1'b1;
        @(negedge clk);
        tick_1m = 1'b0;
        rd(5'h00, v); check("R3", "one tick one decrement", v, 2);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_expiry();
        logic [31:0] v;
        int n = 0;
        wr(5'h04, 32'd5);
        wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h4B);
        while (!reset_req && n < 50) begin @(negedge clk); n++; end
        check("R4", "cycles to reset pulse", n, 6);
        check("R4", "ext pulse with reset", {31'd0, ext_signal}, 1);
        check("R6", "scope cpu", {30'd0, reset_scope}, 2);
        @(negedge clk);
        check("R4", "reset pulse one clock", {31'd0, reset_req}, 0);
        rd(5'h10, v); check("R4", "timeout flag", v, 1);
        idle(5);
        rd(5'h00, v); check("R4", "stopped at zero", v, 0);
        check("R4", "no second pulse", {31'd0, reset_req}, 0);
        wr(5'h08, 32'h4755);
        rd(5'h00, v); check("R2", "restart after expiry", v, 5);
        @(negedge clk);
        rd(5'h00, v); check("R2", "counting resumed", v, 4);
        wr(5'h0C, 32'h0);
        wr(5'h14, 32'h0);
        rd(5'h10, v); check("R8", "clear with bit0 low ignored", v, 1);
        wr(5'h14, 32'h1);
        rd(5'h10, v); check("R8", "clear", v, 0);
    endtask

    task automatic t_pretimeout();
        logic [31:0] v;
        int n = 0;
        wr(5'h04, 32'd1030);
        wr(5'h08, 32'h4755);
        check("R7", "irq idle", {31'd0, irq}, 0);
        wr(5'h0C, 32'h405);
        while (!irq && n < 50) begin @(negedge clk); n++; end
        check("R7", "cycles to irq", n, 7);
        rd(5'h10, v); check("R7", "status pending", v, 4);
        wr(5'h0C, 32'h0);
        check("R7", "irq sticky", {31'd0, irq}, 1);
        wr(5'h14, 32'h1);
        check("R8", "irq cleared", {31'd0, irq}, 0);
        wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h401);
        idle(20);
        rd(5'h00, v); check("R7", "below threshold", {31'd0, v < 32'd1024}, 1);
        check("R7", "no irq when disabled", {31'd0, irq}, 0);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_altboot();
        logic [31:0] v;
        int n = 0;
        bit saw_rst = 0;
        wr(5'h04, 32'd2);
        wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h81);
        while (!alt_boot_req && n < 50) begin
            @(negedge clk); n++;
            if (reset_req) saw_rst = 1;
        end
        check("R9", "cycles to alt boot", n, 3);
        idle(5);
        check("R9", "alt boot held", {31'd0, alt_boot_req}, 1);
        check("R4", "no reset pulse when bit1 clear", {31'd0, saw_rst}, 0);
        rd(5'h10, v); check("R9", "status", v, 3);
        wr(5'h0C, 32'h0);
        wr(5'h14, 32'h1);
        check("R8", "alt boot cleared", {31'd0, alt_boot_req}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_restart_key();
        t_freeze();
        t_tick();
        t_expiry();
        t_pretimeout();
        t_altboot();
        summary();
        $finish;
    end
endmodule